// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Level Mask

This block gathers 64 interrupt sources into two banks of 32 and offers each bank to software as four 32-bit registers in a 64-byte register window. Edge-type sources are caught in a per-bank event latch. Software clears the latch by writing ones to an acknowledge register. A fixed mask marks some sources as level-type. For those sources the pending state follows the synchronized input directly and no latch is involved.

A bank's pending bits are formed as the event latch, plus the masked live level, gated by the bank's enable register. Every pending bit across both banks is ORed into a single registered interrupt request. The number of the highest pending source is reported next to the request, together with a valid flag. When software enables a source whose input is already high, no new event is created. Only a later rising edge is caught.

Top module: `irq_bank_ctrl`

## Requirements
- R1: The bank for sources 32..63 occupies window offsets 0x10..0x1F and the bank for sources 0..31 occupies 0x20..0x2F. Within a bank, byte offset +0x0 is the event register, +0x4 the enable register, +0x8 the acknowledge register and +0xC the level register. Addresses in 0x00..0x0F and 0x30..0x3F read as zero, and writes to them change nothing.
- R2: An enable register reads back exactly the last value written to it and changes only when it is written.
- R3: An edge-type event bit is set when its synchronized input shows a rising edge while its enable bit is set. A rising edge that arrives while the bit is disabled is lost.
- R4: Each 1 written to an acknowledge register clears the matching event bit, and each 0 leaves its bit alone. If a set and an acknowledge hit the same bit in the same cycle, the set wins. A read of the acknowledge register returns zero and changes no state.
- R5: The level register returns the current input states after a two-flop synchronizer.
- R6: Sources 20..28 of the lower bank (mask 0x1ff00000) are level-type. Each of these is pending while its synchronized input is high and it is enabled, stops being pending when the input falls without any acknowledge, and never sets its event bit.
- R7: Setting an enable bit while its source input is already high does not set the event bit and does not raise the request.
- R8: irq_o is the registered OR of all pending bits, where pending = (event OR (level AND mask)) AND enable. It changes one clock after the pending state changes.
- R9: irq_id_o is the registered number of the highest-numbered pending source, so any source in 32..63 outranks every source in 0..31. irq_valid_o is high exactly when something is pending, and irq_id_o is 0 when irq_valid_o is low.
- R10: Reset, which is synchronous and active-low, clears the enable registers, the event registers, irq_o, irq_valid_o and irq_id_o.
- R11: rd_data_o takes the addressed register value on the clock edge where rd_en_i is high, and keeps its value when rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Asynchronous interrupt source inputs |
| addr_i | input | 6 | Byte address within the register window |
| wr_data_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 6 | Number of the highest pending source |
| irq_valid_o | output | 1 | Qualifies irq_id_o |

## Verification
The bench builds the block with its default parameters: two banks of 32 sources, a two-stage synchronizer, and the level mask 0x1ff00000 on the lower bank. This puts level-type and edge-type sources side by side in one bank, with an all-edge bank above it. With these values the bench can check the upper bank outranking the lower bank, level sources that fall without an acknowledge, and a set and an acknowledge colliding on the same bit. Random source toggling and random accesses across the whole window, including the two unused slots, also exercise decode holes and enable-while-high cases.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared register selector encoding and window geometry for the
// banked interrupt controller. Assumes 32-bit registers on word addresses.
package irq_ctrl_pkg;

    // Register selector taken from address bits [3:2] inside a bank slot
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    localparam int REG_BYTES  = 4;
    localparam int SLOT_BYTES = 4 * REG_BYTES;
    localparam int SLOT_LSB   = $clog2(SLOT_BYTES);

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-stage synchronizer for a vector of asynchronous source inputs.
// Assumes each bit is independent; no bus coherency is implied.
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[s] <= '0;
                else if (s == 0)
                    chain_q[s] <= async_i;
                else
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_bank.sv
// Module: irq_bank
// One bank of sources: event latch, enable mask and pending computation.
// Assumes live_i is already synchronized. Edge-type bits latch on a rising
// edge while enabled; level-type bits (LVL_MASK) never latch.
module irq_bank #(
    parameter int           W        = 32,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         en_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] enable_o,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] event_q;
    logic [W-1:0] enable_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr;

    assign rise = live_i & ~prev_q & ~LVL_MASK;
    assign clr  = ack_we_i ? wdata_i : '0;

    // Delay the synchronized inputs by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= live_i;
    end

    // Event latch: acknowledge clears, an enabled rising edge sets (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n)
            event_q <= '0;
        else
            event_q <= (event_q & ~clr) | (rise & enable_q);
    end

    // Enable register: holds the last value written
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (en_we_i)
            enable_q <= wdata_i;
    end

    assign event_o  = event_q;
    assign enable_o = enable_q;
    assign pend_o   = (event_q | (live_i & LVL_MASK)) & enable_q;

endmodule

// File: rtl/irq_prio.sv
// Module: irq_prio
// Finds the highest-numbered set bit across all banks; higher banks outrank
// lower ones. Purely combinational; the caller registers the result.
module irq_prio #(
    parameter int NUM_BANKS = 2,
    parameter int W         = 32,
    localparam int N        = NUM_BANKS * W,
    localparam int ID_W     = $clog2(N)
) (
    input  logic [N-1:0]    pend_i,
    output logic            any_o,
    output logic [ID_W-1:0] id_o
);

    // Scan upward so the last hit, the highest number, is kept
    always_comb begin
        any_o = 1'b0;
        id_o  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int i = 0; i < W; i++) begin
                if (pend_i[b*W + i]) begin
                    any_o = 1'b1;
                    id_o  = ID_W'(b*W + i);
                end
            end
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
// Module: irq_bank_ctrl (top)
// Banked interrupt controller with a register window. Bank b sits at slot
// NUM_BANKS-b, so the lowest sources occupy the highest used slot. Assumes
// word-aligned accesses; addr_i[1:0] is ignored.
module irq_bank_ctrl #(
    parameter int                       BANK_W      = 32,
    parameter int                       NUM_BANKS   = 2,
    parameter int                       SYNC_STAGES = 2,
    parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MASK = 64'h0000_0000_1ff0_0000,
    localparam int                      NUM_SRC     = NUM_BANKS * BANK_W,
    localparam int                      ID_W        = $clog2(NUM_SRC),
    localparam int                      ADDR_W      = irq_ctrl_pkg::SLOT_LSB + $clog2(NUM_BANKS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BANK_W-1:0]  wr_data_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    output logic [BANK_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic               irq_valid_o
);
    import irq_ctrl_pkg::*;

    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] event_vec;
    logic [NUM_SRC-1:0] enable_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [SLOT_W-1:0]  slot;
    reg_sel_e           rsel;
    logic [NUM_BANKS-1:0] hit;
    logic [BANK_W-1:0]  rd_mux;
    logic               any_pend;
    logic [ID_W-1:0]    top_id;
    logic               irq_q;
    logic               vld_q;
    logic [ID_W-1:0]    id_q;
    logic [BANK_W-1:0]  rd_q;

    assign slot = addr_i[ADDR_W-1:SLOT_LSB];
    assign rsel = reg_sel_e'(addr_i[SLOT_LSB-1:2]);

    irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(src_i),
        .sync_o (live)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign hit[b] = (slot == SLOT_W'(NUM_BANKS - b));

            irq_bank #(
                .W       (BANK_W),
                .LVL_MASK(LVL_MASK[b*BANK_W +: BANK_W])
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .live_i  (live[b*BANK_W +: BANK_W]),
                .en_we_i (wr_en_i && hit[b] && rsel == REG_ENABLE),
                .ack_we_i(wr_en_i && hit[b] && rsel == REG_ACK),
                .wdata_i (wr_data_i),
                .event_o (event_vec[b*BANK_W +: BANK_W]),
                .enable_o(enable_vec[b*BANK_W +: BANK_W]),
                .pend_o  (pend_vec[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    irq_prio #(.NUM_BANKS(NUM_BANKS), .W(BANK_W)) u_prio (
        .pend_i(pend_vec),
        .any_o (any_pend),
        .id_o  (top_id)
    );

    // Select the addressed register; the acknowledge register and holes read 0
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b]) begin
                case (rsel)
                    REG_EVENT:  rd_mux = event_vec[b*BANK_W +: BANK_W];
                    REG_ENABLE: rd_mux = enable_vec[b*BANK_W +: BANK_W];
                    REG_LEVEL:  rd_mux = live[b*BANK_W +: BANK_W];
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

    // Capture read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en_i)
            rd_q <= rd_mux;
    end

    // Register the combined request, the winning number and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vld_q <= 1'b0;
            id_q  <= '0;
        end else begin
            irq_q <= |pend_vec;
            vld_q <= any_pend;
            id_q  <= any_pend ? top_id : '0;
        end
    end

    assign rd_data_o   = rd_q;
    assign irq_o       = irq_q;
    assign irq_valid_o = vld_q;
    assign irq_id_o    = id_q;

endmodule

// File: rtl/irq_bank_ctrl_chk.sv
// Module: irq_bank_ctrl_chk
// Assertion checker bound into irq_bank_ctrl. Observes ports and the
// flattened event and enable state; drives nothing.
module irq_bank_ctrl_chk #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 6,
    parameter int ID_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wr_en_i,
    input logic               irq_o,
    input logic               irq_valid_o,
    input logic [ID_W-1:0]    irq_id_o,
    input logic [NUM_SRC-1:0] event_vec,
    input logic [NUM_SRC-1:0] enable_vec
);

    logic en_write;
    assign en_write = wr_en_i && addr_i[3:2] == 2'd1 &&
                      (addr_i[ADDR_W-1:4] != '0) &&
                      (addr_i[ADDR_W-1:4] != {(ADDR_W-4){1'b1}});

    // R8: request and valid come from separate paths and must agree
    assert_irq_valid_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == irq_valid_o);

    // R9: the source number is zero whenever nothing is pending
    assert_id_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> irq_id_o == '0);

    // R10: a reset cycle leaves the controller quiet
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !irq_valid_o && event_vec == '0 && enable_vec == '0));

    // R2: enable state changes only through an enable register write
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_write |=> $stable(enable_vec));

    // R3: a newly set event bit must have been enabled the cycle before
    assert_event_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((event_vec & ~$past(event_vec) & ~$past(enable_vec)) == '0));

endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .irq_o      (irq_o),
    .irq_valid_o(irq_valid_o),
    .irq_id_o   (irq_id_o),
    .event_vec  (event_vec),
    .enable_vec (enable_vec)
);

// File: tb/irq_bank_ctrl_test.sv
// Bench for irq_bank_ctrl: cycle model computed from the requirements,
// directed corner cases, then fixed-seed random traffic.
module irq_bank_ctrl_test;

    localparam logic [63:0] LM = 64'h0000_0000_1ff0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    logic [5:0]  irq_id;
    logic        irq_valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // model state
    logic [63:0] m_s1 = '0, m_s2 = '0, m_sd = '0, m_ev = '0, m_en = '0;
    logic        m_irq = 0, m_vld = 0;
    logic [5:0]  m_id = '0;
    logic [31:0] m_rd = '0;

    always #5 clk = ~clk;

    irq_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_data_i(wdata), .wr_en_i(we), .rd_en_i(re),
        .rd_data_o(rd_data), .irq_o(irq), .irq_id_o(irq_id),
        .irq_valid_o(irq_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R1: bank for sources 0..31 in slot 2, sources 32..63 in slot 1
    function automatic int bank_of(input logic [5:0] a);
        if (a[5:4] == 2'd2) return 0;
        if (a[5:4] == 2'd1) return 1;
        return -1;
    endfunction

    function automatic logic [5:0] top_bit(input logic [63:0] v);
        logic [5:0] r = '0;
        for (int i = 0; i < 64; i++) if (v[i]) r = 6'(i);
        return r;
    endfunction

    // Advance one clock: compute expected next state, then compare outputs
    task automatic tick();
        logic [63:0] ack, rise, pend, n_ev, n_en;
        logic [31:0] n_rd;
        int b;
        b = bank_of(addr);
        ack = '0; n_en = m_en; n_rd = m_rd;
        if (we && b >= 0 && addr[3:2] == 2'd2) ack[b*32 +: 32] = wdata;
        if (we && b >= 0 && addr[3:2] == 2'd1) n_en[b*32 +: 32] = wdata;
        if (re) begin
            n_rd = '0;
            if (b >= 0) case (addr[3:2])
                2'd0: n_rd = m_ev[b*32 +: 32];
                2'd1: n_rd = m_en[b*32 +: 32];
                2'd3: n_rd = m_s2[b*32 +: 32];
                default: n_rd = '0;
            endcase
        end
        rise = m_s2 & ~m_sd & ~LM;
        n_ev = (m_ev & ~ack) | (rise & m_en);
        pend = (m_ev | (m_s2 & LM)) & m_en;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_sd = '0; m_ev = '0; m_en = '0;
            m_irq = 0; m_vld = 0; m_id = '0; m_rd = '0;
        end else begin
            m_sd = m_s2; m_s2 = m_s1; m_s1 = src;
            m_ev = n_ev; m_en = n_en; m_rd = n_rd;
            m_irq = |pend; m_vld = |pend; m_id = (|pend) ? top_bit(pend) : '0;
        end
        chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
        chk("R9 valid", {31'd0, irq_valid}, {31'd0, m_vld});
        chk("R9 id", {26'd0, irq_id}, {26'd0, m_id});
        chk("R11 rd_data", rd_data, m_rd);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        tick();
        re = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        logic [31:0] d;
        int unused;
        unused = $urandom(32'd1234);
        idle(4);
        // R10: reset state
        chk("R10 irq after reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        rd(6'h24, d); chk("R10 enable lo cleared", d, 32'd0);
        rd(6'h14, d); chk("R10 enable hi cleared", d, 32'd0);

        // R2 / R1: enable readback and placement
        wr(6'h24, 32'hA5A5_0F0F);
        wr(6'h14, 32'h1234_5678);
        rd(6'h24, d); chk("R2 enable lo readback", d, 32'hA5A5_0F0F);
        rd(6'h14, d); chk("R2 enable hi readback", d, 32'h1234_5678);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h34, 32'hFFFF_FFFF);
        rd(6'h24, d); chk("R1 hole write ignored", d, 32'hA5A5_0F0F);
        rd(6'h04, d); chk("R1 hole reads zero", d, 32'd0);
        wr(6'h24, 32'd0); wr(6'h14, 32'd0);

        // R3: enabled edge latches
        wr(6'h24, 32'h0000_0008);
        src[3] = 1'b1; idle(4);
        rd(6'h20, d); chk("R3 event latched", d, 32'h0000_0008);
        chk("R8 irq on edge", {31'd0, irq}, 32'd1);
        // R4: ack read has no effect, ack write clears
        rd(6'h28, d); chk("R4 ack reads zero", d, 32'd0);
        rd(6'h20, d); chk("R4 ack read no side effect", d, 32'h0000_0008);
        wr(6'h28, 32'h0000_0004);
        rd(6'h20, d); chk("R4 zero bits untouched", d, 32'h0000_0008);
        wr(6'h28, 32'h0000_0008);
        idle(1);
        rd(6'h20, d); chk("R4 ack clears", d, 32'd0);
        chk("R8 irq drops after ack", {31'd0, irq}, 32'd0);
        src[3] = 1'b0;

        // R4: set wins against simultaneous ack
        wr(6'h24, 32'h0000_0020);
        src[5] = 1'b1; idle(2);
        wr(6'h28, 32'h0000_0020);
        rd(6'h20, d); chk("R4 set wins over ack", d, 32'h0000_0020);
        wr(6'h28, 32'h0000_0020);
        src[5] = 1'b0; wr(6'h24, 32'd0);

        // R7: enable while input already high
        src[7] = 1'b1; idle(4);
        wr(6'h24, 32'h0000_0080);
        idle(3);
        rd(6'h20, d); chk("R7 no event on late enable", d, 32'd0);
        chk("R7 no irq on late enable", {31'd0, irq}, 32'd0);
        src[7] = 1'b0; idle(3); src[7] = 1'b1; idle(4);
        rd(6'h20, d); chk("R3 later edge caught", d, 32'h0000_0080);
        wr(6'h28, 32'h0000_0080); src[7] = 1'b0; wr(6'h24, 32'd0);

        // R5 / R6: level register and level-type source 22
        wr(6'h24, 32'h0040_0000);
        src[22] = 1'b1; src[40] = 1'b1; idle(3);
        rd(6'h2C, d); chk("R5 level lo", d, 32'h0040_0000);
        rd(6'h1C, d); chk("R5 level hi", d, 32'h0000_0100);
        chk("R6 level pending id", {26'd0, irq_id}, 32'd22);
        rd(6'h20, d); chk("R6 no event latch", d, 32'd0);
        src[22] = 1'b0; idle(4);
        chk("R6 drops without ack", {31'd0, irq}, 32'd0);
        src[40] = 1'b0; wr(6'h24, 32'd0);

        // R9: upper bank outranks lower bank
        wr(6'h24, 32'h8000_0000); wr(6'h14, 32'h0000_0001);
        src[31] = 1'b1; src[32] = 1'b1; idle(4);
        chk("R9 upper bank wins", {26'd0, irq_id}, 32'd32);
        wr(6'h18, 32'h0000_0001); idle(1);
        chk("R9 falls to lower bank", {26'd0, irq_id}, 32'd31);
        wr(6'h28, 32'h8000_0000); idle(1);
        chk("R9 idle id zero", {26'd0, irq_id}, 32'd0);
        src = '0; wr(6'h24, 32'd0); wr(6'h14, 32'd0);

        // Random traffic, all requirements checked per cycle by the model
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 4) == 0) src[$urandom % 64] ^= 1'b1;
            we = (($urandom % 5) == 0);
            re = !we && (($urandom % 3) == 0);
            addr = 6'($urandom);
            wdata = (addr[3:2] == 2'd1) ? $urandom : (32'd1 << ($urandom % 32));
            tick();
        end
        we = 0; re = 0;

        // R10: reset mid-run clears everything
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        rd(6'h24, d); chk("R10 enable cleared by reset", d, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule